// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets a host drive a small three-wire serial configuration EEPROM through two registers. The EEPROM holds 64 words of 16 bits. The host may load a write-data register at any time. It then writes a command word whose low byte holds a two-bit opcode above a six-bit word address.

Once a command is accepted, the block drives chip select and generates the serial clock from the system clock. It shifts out a start bit, the opcode and the address, most significant bit first. A write also shifts out the 16 data bits. A read instead clocks in 16 data bits. A busy bit stays set from acceptance until the sequence ends.

Read results land in a separate read-data register, which holds them until the next read completes. Writes and erases are only issued after an erase/write enable command has been run. Commands that arrive while busy are dropped.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_status` and `rd_data` are 0, and `ee_cs`, `ee_sk` and `ee_di` are low.
- R2: Command word 0x0080|a (opcode 10 in bits 7:6, address in bits 5:0) runs a read. The serial output is a 1 start bit, then bits 7:0 of the command MSB first. Then 16 serial clocks sample `ee_do` MSB first, and the word is placed in `rd_data`.
- R3: Command word 0x0040|a (opcode 01) runs a write. The 9-bit header is followed by the 16 bits of the write-data register, MSB first.
- R4: Command word 0x00C0|a (opcode 11) runs an erase, and 0x0030 (opcode 00 with address bits 5:4 = 11) runs the erase/write enable. Each sends only the 9-bit header. Enable arms a latch that stays set until reset.
- R5: A write or erase command issued before the enable has completed is dropped: busy stays 0 and chip select never rises.
- R6: Bit 15 of `cmd_status` is 1 from the cycle after acceptance for exactly (2N+1)·CLK_DIV cycles. N is 25 for read and write, and 9 for erase and enable.
- R7: A command word written while busy is dropped and does not disturb the running operation.
- R8: Bit 14 of `cmd_status` is the test-mode flag and equals bit 14 of the last accepted command word. Bits 7:0 show the last accepted command byte, and bits 13:8 read 0. The flag does not change the serial sequence.
- R9: `rd_data` changes only when a read completes; writes, erases and enables leave it alone.
- R10: `ee_sk` is high only while `ee_cs` is high, each high phase lasts CLK_DIV system clocks, and `ee_di` does not change on a rising `ee_sk`.
- R11: An opcode-00 command whose address bits 5:4 are not 11 is dropped; busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command word, 1 = write-data register |
| reg_wdata | input | 16 | Register write value |
| cmd_status | output | 16 | {busy, test flag, 6'b0, last command byte} |
| rd_data | output | 16 | Last word read from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Two situations are hard to reach from the ports: the gated write that must not happen before enable, and a command that lands in the middle of a running read. The bench issues writes and erases right after reset and counts chip-select rises in its EEPROM model. It then starts a read and, a few cycles later, writes a conflicting write command with fresh write data. Afterwards it checks both the read result and the untouched target word. Once enable has run, every address is written with an arithmetically derived pattern and read back, with the serial header decoded by the model at each step.

// File: rtl/eectl_pkg.sv
// Shared opcode encodings and operation kinds for the serial EEPROM controller.
// Assumes a two-bit opcode placed directly above the word address.
package eectl_pkg;
    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_READ,
        OPK_WRITE,
        OPK_ERASE,
        OPK_ENABLE
    } op_kind_t;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;
    localparam logic [1:0] SUB_ENABLE  = 2'b11;
endpackage

// File: rtl/eectl_gate.sv
// Command gate: classifies a host command word and decides whether it starts.
// It holds the erase/write enable latch, which is armed when an enable
// sequence completes. Assumes ADDR_W >= 2.
module eectl_gate
    import eectl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_word,
    input  logic        busy,
    input  logic        enable_done,
    output logic        accept,
    output op_kind_t    kind,
    output logic        armed
);
    logic [1:0] opc;
    logic [1:0] sub;
    logic       gated;

    assign opc = cmd_word[ADDR_W+1:ADDR_W];
    assign sub = cmd_word[ADDR_W-1:ADDR_W-2];

    // Map the opcode field (and sub-field for opcode 00) to an operation kind.
    always_comb begin
        unique case (opc)
            OPC_READ:  kind = OPK_READ;
            OPC_WRITE: kind = OPK_WRITE;
            OPC_ERASE: kind = OPK_ERASE;
            default:   kind = (sub == SUB_ENABLE) ? OPK_ENABLE : OPK_NONE;
        endcase
    end

    // Start only when idle, the code is known, and writes/erases are armed.
    always_comb begin
        gated  = (kind == OPK_WRITE || kind == OPK_ERASE) && !armed;
        accept = cmd_wr && !busy && (kind != OPK_NONE) && !gated;
    end

    // Enable latch: set once an enable sequence finishes, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (enable_done)
            armed <= 1'b1;
    end

    // R4
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(armed));
endmodule

// File: rtl/eectl_tick.sv
// Serial clock divider: while enabled, pulses tick once every DIV system
// clocks; the count restarts from zero whenever the enable drops.
module eectl_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count system clocks inside the current half serial period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R10
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/eectl_seq.sv
// Serial sequencer: frames one EEPROM operation. On start it raises chip
// select, then shifts out a start bit and the command header, MSB first.
// Writes follow with the data word; reads sample 16 bits. Each bit takes two
// ticks (clock low, then high). Chip select drops after the last bit, and one
// idle tick separates operations. Assumes tick comes from a divider that is
// enabled while busy.
module eectl_seq
    import eectl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_t          kind,
    input  logic [ADDR_W+1:0] hdr_bits,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              so_in,
    output logic              busy,
    output logic              cs,
    output logic              sk,
    output logic              si,
    output logic              done,
    output op_kind_t          done_kind,
    output logic [DATA_W-1:0] rd_word
);
    localparam int HDR_W  = ADDR_W + 3;
    localparam int LONG_N = HDR_W + DATA_W;
    localparam int CNT_W  = $clog2(LONG_N + 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_N - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(HDR_W);

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} seq_st_t;

    seq_st_t           st_q;
    op_kind_t          kind_q;
    logic [LONG_N-1:0] sh_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CNT_W-1:0]  last_q;
    logic              cs_q;
    logic              sk_q;
    logic [DATA_W-1:0] rd_q;

    assign busy      = (st_q != ST_IDLE);
    assign cs        = cs_q;
    assign sk        = sk_q;
    assign si        = cs_q & sh_q[LONG_N-1];
    assign done      = (st_q == ST_GAP) && tick;
    assign done_kind = kind_q;
    assign rd_word   = rd_q;

    // Frame state, shift register, bit counter and serial pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= OPK_NONE;
            sh_q   <= '0;
            bit_q  <= '0;
            last_q <= '0;
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            rd_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q   <= ST_SHIFT;
                    kind_q <= kind;
                    sh_q   <= {1'b1, hdr_bits,
                               (kind == OPK_WRITE) ? wdata : {DATA_W{1'b0}}};
                    bit_q  <= '0;
                    last_q <= (kind == OPK_READ || kind == OPK_WRITE)
                              ? LAST_LONG : LAST_SHORT;
                    cs_q   <= 1'b1;
                    sk_q   <= 1'b0;
                end
                ST_SHIFT: if (tick) begin
                    if (!sk_q) begin
                        sk_q <= 1'b1;
                        if (kind_q == OPK_READ && bit_q >= DATA_FIRST)
                            rd_q <= {rd_q[DATA_W-2:0], so_in};
                    end else begin
                        sk_q <= 1'b0;
                        if (bit_q == last_q) begin
                            cs_q <= 1'b0;
                            st_q <= ST_GAP;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[LONG_N-2:0], 1'b0};
                        end
                    end
                end
                ST_GAP: if (tick) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    sk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sk_q |-> cs_q);

    // R10
    di_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_q) |-> $stable(si));

    // R6
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q) |-> $past(start));
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
// Top of the serial EEPROM command controller. Holds the host-visible
// registers: the command/status word, the write-data word and the read-data
// word. The command gate, serial clock divider and sequencer run the serial
// traffic. Assumes ADDR_W <= 12 so that the command byte fits below bit 14.
module eeprom_cmd_ctrl
    import eectl_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] cmd_status,
    output logic [15:0] rd_data,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    localparam int DATA_W = 16;
    localparam int CMD_W  = ADDR_W + 2;
    localparam int PAD_W  = 14 - CMD_W;

    logic              busy;
    logic              accept;
    op_kind_t          kind;
    logic              armed;
    logic              tick;
    logic              seq_done;
    op_kind_t          done_kind;
    logic [DATA_W-1:0] rd_word;
    logic [CMD_W-1:0]  cmd_q;
    logic              test_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data_q;

    eectl_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (reg_wr && !reg_sel),
        .cmd_word    (reg_wdata),
        .busy        (busy),
        .enable_done (seq_done && done_kind == OPK_ENABLE),
        .accept      (accept),
        .kind        (kind),
        .armed       (armed)
    );

    eectl_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    eectl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .kind      (kind),
        .hdr_bits  (reg_wdata[CMD_W-1:0]),
        .wdata     (wdata_q),
        .tick      (tick),
        .so_in     (ee_do),
        .busy      (busy),
        .cs        (ee_cs),
        .sk        (ee_sk),
        .si        (ee_di),
        .done      (seq_done),
        .done_kind (done_kind),
        .rd_word   (rd_word)
    );

    // Latch the command byte and test flag of each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            test_q <= 1'b0;
        end else if (accept) begin
            cmd_q  <= reg_wdata[CMD_W-1:0];
            test_q <= reg_wdata[14];
        end
    end

    // Host write-data register, loadable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (reg_wr && reg_sel)
            wdata_q <= reg_wdata;
    end

    // Read-data register: updated only when a read sequence completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_q <= '0;
        else if (seq_done && done_kind == OPK_READ)
            rd_data_q <= rd_word;
    end

    assign cmd_status = {busy, test_q, {PAD_W{1'b0}}, cmd_q};
    assign rd_data    = rd_data_q;

    // R5
    unarmed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && !reg_sel && !armed &&
         (reg_wdata[CMD_W-1:ADDR_W] == OPC_WRITE ||
          reg_wdata[CMD_W-1:ADDR_W] == OPC_ERASE)) |=> !busy);

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && !reg_sel) |=> ($stable(cmd_q) && $stable(test_q)));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data_q) |-> $past(seq_done && done_kind == OPK_READ));
endmodule

// File: tb/test_eeprom_cmd_ctrl.sv
// Self-checking bench with a behavioural 64 x 16 serial EEPROM model.
module test_eeprom_cmd_ctrl;
    localparam int D = 4;
    localparam int LONG_CYC  = 51 * D;
    localparam int SHORT_CYC = 19 * D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] cmd_status;
    logic [15:0] rd_data;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    eeprom_cmd_ctrl #(.ADDR_W(6), .CLK_DIV(D)) i_eeprom_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_status(cmd_status), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    logic [15:0] expv [64];
    logic        m_en = 1'b0;
    int          m_k = 0;
    logic [8:0]  m_hdr = 9'h0;
    logic [15:0] m_wd = 16'h0;
    logic [8:0]  last_hdr = 9'h0;
    int          cs_starts = 0;

    function automatic logic [15:0] init_word(input int a);
        if (a == 7) return 16'h6D50;
        if (a == 3) return 16'h9150;
        return 16'((a * 16'h0101) ^ 16'h1234);
    endfunction

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0461) ^ 16'hA5C3);
    endfunction

    always @(posedge ee_cs) begin
        m_k = 0; m_hdr = 9'h0; m_wd = 16'h0; cs_starts++;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            m_k++;
            if (m_k <= 9) m_hdr = {m_hdr[7:0], ee_di};
            else if (m_k <= 25) m_wd = {m_wd[14:0], ee_di};
            if (m_k >= 9 && m_k < 25 && m_hdr[7:6] == 2'b10)
                ee_do = mem[m_hdr[5:0]][24 - m_k];
        end
    end

    always @(negedge ee_cs) begin
        last_hdr = m_hdr;
        case (m_hdr[7:6])
            2'b00: if (m_hdr[5:4] == 2'b11) m_en = 1'b1;
            2'b01: if (m_en && m_k == 25) mem[m_hdr[5:0]] = m_wd;
            2'b11: if (m_en) mem[m_hdr[5:0]] = 16'hFFFF;
            default: ;
        endcase
    end

    // ---------------- serial timing monitor (R10) ----------------
    int sk_run = 0;
    int bad_runs = 0;
    int sk_no_cs = 0;
    always @(negedge clk) begin
        if (ee_sk) begin
            sk_run++;
            if (!ee_cs) sk_no_cs++;
        end else if (sk_run != 0) begin
            if (sk_run != D) bad_runs++;
            sk_run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_wdata(input logic [15:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic issue(input logic [15:0] w, output int cyc);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        cyc = 0;
        while (cmd_status[15]) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic read_word(input int a, output logic [15:0] v, output int cyc);
        issue(16'(16'h0080 | a), cyc);
        v = rd_data;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int cyc;
        int starts0;
        logic [15:0] v;
        for (int a = 0; a < 64; a++) begin
            mem[a] = init_word(a);
            expv[a] = init_word(a);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", cmd_status, 16'h0000);
        check("R1 rd_data", rd_data, 16'h0000);
        check("R1 pins", {ee_cs, ee_sk, ee_di}, 3'b000);
        rst_n = 1'b1;

        // R2 reads of identity words, R6 timing
        read_word(7, v, cyc);
        check("R2 word7", v, 16'h6D50);
        check("R2 header", last_hdr, 9'h187);
        check("R6 read busy", cyc, LONG_CYC);
        read_word(3, v, cyc);
        check("R2 word3", v, 16'h9150);

        // R11 undefined special codes
        starts0 = cs_starts;
        issue(16'h0000, cyc);
        check("R11 busy", cyc, 0);
        issue(16'h0010, cyc);
        check("R11 busy", cyc, 0);
        check("R11 no cs", cs_starts, starts0);

        // R5 write and erase before enable
        set_wdata(16'hBEEF);
        issue(16'h0045, cyc);
        check("R5 write busy", cyc, 0);
        issue(16'h00C5, cyc);
        check("R5 erase busy", cyc, 0);
        check("R5 no cs", cs_starts, starts0);
        read_word(5, v, cyc);
        check("R5 word5 kept", v, expv[5]);

        // R4 enable
        issue(16'h0030, cyc);
        check("R4 enable header", last_hdr, 9'h130);
        check("R6 enable busy", cyc, SHORT_CYC);

        // R3 write sweep over all addresses
        for (int a = 0; a < 64; a++) begin
            set_wdata(pat(a));
            issue(16'(16'h0040 | a), cyc);
            expv[a] = pat(a);
            check("R3 header", last_hdr, 9'(9'h140 | a));
            check("R6 write busy", cyc, LONG_CYC);
        end
        // R2 read-back sweep
        for (int a = 0; a < 64; a++) begin
            read_word(a, v, cyc);
            check("R2 readback", v, expv[a]);
        end

        // R4 erase
        for (int i = 0; i < 3; i++) begin
            int a;
            a = (i == 0) ? 0 : (i == 1) ? 31 : 63;
            issue(16'(16'h00C0 | a), cyc);
            expv[a] = 16'hFFFF;
            check("R6 erase busy", cyc, SHORT_CYC);
            check("R4 erase header", last_hdr, 9'(9'h1C0 | a));
            read_word(a, v, cyc);
            check("R4 erased", v, 16'hFFFF);
        end

        // R9 read data holds across non-read operations
        read_word(10, v, cyc);
        set_wdata(16'h0F0F);
        issue(16'h004B, cyc);
        expv[11] = 16'h0F0F;
        check("R9 after write", rd_data, expv[10]);
        issue(16'h00CC, cyc);
        expv[12] = 16'hFFFF;
        check("R9 after erase", rd_data, expv[10]);

        // R7 command during busy
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0094;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h5A5A;
        @(negedge clk);
        reg_sel = 1'b0; reg_wdata = 16'h0055;
        @(negedge clk);
        reg_wr = 1'b0;
        while (cmd_status[15]) @(negedge clk);
        check("R7 read result", rd_data, expv[20]);
        check("R7 header", last_hdr, 9'h194);
        check("R7 status", cmd_status, 16'h0094);
        read_word(21, v, cyc);
        check("R7 word21 kept", v, expv[21]);

        // R8 test flag
        issue(16'h4082, cyc);
        check("R8 flag set", cmd_status, 16'h4082);
        check("R8 no effect", rd_data, expv[2]);
        check("R8 header", last_hdr, 9'h182);
        check("R6 test read busy", cyc, LONG_CYC);
        issue(16'h0083, cyc);
        check("R8 flag clear", cmd_status, 16'h0083);
        check("R8 read", rd_data, expv[3]);

        // R10 serial clock shape
        check("R10 sk width", bad_runs, 0);
        check("R10 sk without cs", sk_no_cs, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule